// File: doc/BRIEF.md
# Stateless Programmable Functional Unit

This block is an extra execution unit placed next to a processor's register file. It runs user-defined instructions. The issue logic hands it two source operands and the numeric function ID of the requested operation. In return it produces one destination value or a miss fault. The unit keeps exactly one loaded configuration: a function ID plus a bank of lookup-table bits, with one 16-entry table for each bit slice of the datapath.

The datapath between the operands and the result register is purely combinational. No operation leaves anything behind for the next one, so a context switch never needs to save or restore the unit. On every issue the requested ID is compared with the loaded ID.
- On a match, the result is registered and presented in the next cycle.
- On a mismatch, or when nothing has been loaded yet, the unit raises a fault for that one cycle instead. Trap software then loads the right configuration and re-issues the instruction.

Configuration arrives on a write port. The port has one strobe for the function ID and one for a single slice table, selected by slice number.

Top module: `pfu_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_vld` and `res_fault` are low and `res_data` is zero. Reset also marks the configuration as not loaded.
- R2: An issue made before any function-ID write results in `res_fault` high and `res_vld` low in the following cycle.
- R3: An issue whose 11-bit ID equals the loaded ID gives `res_vld` high, `res_fault` low and the computed value on `res_data` in the cycle after the issue edge.
- R4: An issue whose ID differs from the loaded ID gives `res_fault` high for exactly that one cycle, with `res_vld` low and `res_data` zero.
- R5: Result bit i equals bit k of slice i's 16-bit table, with k = A[i] + 2·B[i] + 4·A[i-1] + 8·B[i-1]. A[-1] and B[-1] are taken as 0.
- R6: A configuration write (ID or table) made in the same cycle as an issue does not affect that issue. It applies from the next issue onward.
- R7: A cycle without an issue yields `res_vld` and `res_fault` low and `res_data` zero in the following cycle. Back-to-back issues depend only on their own operands and the configuration.
- R8: `res_vld` and `res_fault` are never high together.
- R9: All 11 bits of the ID take part in the comparison. An ID that differs only in its top bit faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue strobe |
| iss_fid | input | FID_W (11) | Requested function ID |
| iss_a | input | W (32) | First source operand |
| iss_b | input | W (32) | Second source operand |
| res_vld | output | 1 | Result valid, one cycle after a matching issue |
| res_fault | output | 1 | Miss fault, one cycle after a non-matching issue |
| res_data | output | W (32) | Result value, zero unless `res_vld` |
| cfg_fid_we | input | 1 | Write strobe for the loaded function ID |
| cfg_fid | input | FID_W (11) | Function ID to load |
| cfg_lut_we | input | 1 | Write strobe for one slice table |
| cfg_lut_sel | input | $clog2(W) (5) | Slice number to write |
| cfg_lut_bits | input | 16 | Table contents for the selected slice |

## Verification
All three outputs come from one register stage. An issue sampled at a rising edge therefore shows up exactly one cycle later as a result, a fault or quiet outputs. A configuration write lands at the same edge, so it first affects the issue sampled at the next edge. The bench applies each stimulus 1 ns after a rising edge and samples 1 ns after the following rising edge. It compares all three outputs on every cycle against a behavioural model. The model computes its prediction from the configuration as it stood before that cycle's writes, and only then applies the writes.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  // Inputs per slice table: A[i], B[i], A[i-1], B[i-1]
  localparam int LUT_IN   = 4;
  localparam int LUT_BITS = 1 << LUT_IN;

  typedef logic [LUT_BITS-1:0] lut_t;

  // Table address: bit0=A[i], bit1=B[i], bit2=A[i-1], bit3=B[i-1]
  function automatic logic [LUT_IN-1:0] lut_addr(input logic a_cur, input logic b_cur,
                                                  input logic a_prv, input logic b_prv);
    return {b_prv, a_prv, b_cur, a_cur};
  endfunction
endpackage

// File: rtl/pfu_cfg_store.sv
module pfu_cfg_store
  import pfu_pkg::*;
#(
  parameter int W     = 32,
  parameter int FID_W = 11,
  localparam int SEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fid_we,
  input  logic [FID_W-1:0]   fid_in,
  input  logic               lut_we,
  input  logic [SEL_W-1:0]   lut_sel,
  input  lut_t               lut_in,
  output logic               cfg_ok,
  output logic [FID_W-1:0]   cur_fid,
  output logic [W*LUT_BITS-1:0] lut_flat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ok  <= 1'b0;
      cur_fid <= '0;
    end else if (fid_we) begin
      cfg_ok  <= 1'b1;
      cur_fid <= fid_in;
    end
  end

  // Table bits carry no reset; every slice is read in parallel
  for (genvar i = 0; i < W; i++) begin : g_tbl
    lut_t tbl_q;
    always_ff @(posedge clk) begin
      if (lut_we && lut_sel == SEL_W'(i))
        tbl_q <= lut_in;
    end
    assign lut_flat[i*LUT_BITS +: LUT_BITS] = tbl_q;
  end
endmodule

// File: rtl/pfu_lut_array.sv
module pfu_lut_array
  import pfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic [W*LUT_BITS-1:0] lut_flat,
  output logic [W-1:0]          y
);
  for (genvar i = 0; i < W; i++) begin : g_slice
    logic a_prv, b_prv;
    lut_t tbl;
    if (i == 0) begin : g_lsb
      assign a_prv = 1'b0;
      assign b_prv = 1'b0;
    end else begin : g_upr
      assign a_prv = a[i-1];
      assign b_prv = b[i-1];
    end
    assign tbl  = lut_flat[i*LUT_BITS +: LUT_BITS];
    assign y[i] = tbl[lut_addr(a[i], b[i], a_prv, b_prv)];
  end
endmodule

// File: rtl/pfu_id_check.sv
module pfu_id_check #(
  parameter int FID_W = 11
) (
  input  logic             iss_vld,
  input  logic [FID_W-1:0] iss_fid,
  input  logic             cfg_ok,
  input  logic [FID_W-1:0] cur_fid,
  output logic             hit,
  output logic             miss
);
  logic same;
  assign same = cfg_ok && (iss_fid == cur_fid);
  assign hit  = iss_vld && same;
  assign miss = iss_vld && !same;
endmodule

// File: rtl/pfu_unit.sv
module pfu_unit
  import pfu_pkg::*;
#(
  parameter int W     = 32,
  parameter int FID_W = 11,
  localparam int SEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_vld,
  input  logic [FID_W-1:0] iss_fid,
  input  logic [W-1:0]     iss_a,
  input  logic [W-1:0]     iss_b,
  output logic             res_vld,
  output logic             res_fault,
  output logic [W-1:0]     res_data,
  input  logic             cfg_fid_we,
  input  logic [FID_W-1:0] cfg_fid,
  input  logic             cfg_lut_we,
  input  logic [SEL_W-1:0] cfg_lut_sel,
  input  logic [LUT_BITS-1:0] cfg_lut_bits
);
  logic                  cfg_ok;
  logic [FID_W-1:0]      cur_fid;
  logic [W*LUT_BITS-1:0] lut_flat;
  logic [W-1:0]          fn_out;
  logic                  hit, miss;

  pfu_cfg_store #(.W(W), .FID_W(FID_W)) u_cfg (
    .clk(clk), .rst(rst),
    .fid_we(cfg_fid_we), .fid_in(cfg_fid),
    .lut_we(cfg_lut_we), .lut_sel(cfg_lut_sel), .lut_in(cfg_lut_bits),
    .cfg_ok(cfg_ok), .cur_fid(cur_fid), .lut_flat(lut_flat)
  );

  pfu_lut_array #(.W(W)) u_fn (
    .a(iss_a), .b(iss_b), .lut_flat(lut_flat), .y(fn_out)
  );

  pfu_id_check #(.FID_W(FID_W)) u_id (
    .iss_vld(iss_vld), .iss_fid(iss_fid),
    .cfg_ok(cfg_ok), .cur_fid(cur_fid),
    .hit(hit), .miss(miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_fault <= 1'b0;
      res_data  <= '0;
    end else begin
      res_vld   <= hit;
      res_fault <= miss;
      res_data  <= hit ? fn_out : '0;
    end
  end
endmodule

// File: rtl/pfu_unit_chk.sv
module pfu_unit_chk #(
  parameter int W     = 32,
  parameter int FID_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_vld,
  input logic [FID_W-1:0] iss_fid,
  input logic             res_vld,
  input logic             res_fault,
  input logic [W-1:0]     res_data,
  input logic             cfg_fid_we,
  input logic [FID_W-1:0] cfg_fid
);
  logic             seen;
  logic [FID_W-1:0] last_fid;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      last_fid <= '0;
    end else if (cfg_fid_we) begin
      seen     <= 1'b1;
      last_fid <= cfg_fid;
    end
  end

  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_vld && res_fault));

  // R7
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_vld |=> (!res_vld && !res_fault && res_data == '0));

  // R2
  unloaded_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && !seen) |=> res_fault);

  // R3
  hit_result_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && seen && iss_fid == last_fid) |=> (res_vld && !res_fault));

  // R4
  miss_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && seen && iss_fid != last_fid) |=> (res_fault && !res_vld && res_data == '0));
endmodule

bind pfu_unit pfu_unit_chk #(.W(W), .FID_W(FID_W)) u_chk (
  .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_fid(iss_fid),
  .res_vld(res_vld), .res_fault(res_fault), .res_data(res_data),
  .cfg_fid_we(cfg_fid_we), .cfg_fid(cfg_fid)
);

// File: tb/pfu_unit_test.sv
`timescale 1ns/1ps
module pfu_unit_test;
  localparam int W     = 32;
  localparam int FID_W = 11;
  localparam int SEL_W = $clog2(W);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             iss_vld = 1'b0;
  logic [FID_W-1:0] iss_fid = '0;
  logic [W-1:0]     iss_a = '0, iss_b = '0;
  logic             res_vld, res_fault;
  logic [W-1:0]     res_data;
  logic             cfg_fid_we = 1'b0;
  logic [FID_W-1:0] cfg_fid = '0;
  logic             cfg_lut_we = 1'b0;
  logic [SEL_W-1:0] cfg_lut_sel = '0;
  logic [15:0]      cfg_lut_bits = '0;

  int total = 0, bad = 0;

  // behavioural model of the loaded configuration
  logic [15:0]      m_tbl [W];
  logic [FID_W-1:0] m_fid = '0;
  bit               m_ok = 1'b0;

  always #2 clk = ~clk;

  pfu_unit #(.W(W), .FID_W(FID_W)) uut (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_fid(iss_fid),
    .iss_a(iss_a), .iss_b(iss_b), .res_vld(res_vld), .res_fault(res_fault),
    .res_data(res_data), .cfg_fid_we(cfg_fid_we), .cfg_fid(cfg_fid),
    .cfg_lut_we(cfg_lut_we), .cfg_lut_sel(cfg_lut_sel), .cfg_lut_bits(cfg_lut_bits)
  );

  function automatic logic [W-1:0] model_fn(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] y = '0;
    for (int i = 0; i < W; i++) begin
      int k = int'(a[i]) + 2*int'(b[i]);
      if (i > 0) k += 4*int'(a[i-1]) + 8*int'(b[i-1]);
      y[i] = m_tbl[i][k];
    end
    return y;
  endfunction

  task automatic check(input string tag, input logic ev, input logic ef, input logic [W-1:0] ed);
    total++;
    if (res_vld !== ev || res_fault !== ef || res_data !== ed) begin
      bad++;
      $display("FAIL %s: got vld=%b fault=%b data=%h, expected vld=%b fault=%b data=%h",
               tag, res_vld, res_fault, res_data, ev, ef, ed);
    end
  endtask

  // One cycle: apply stimulus, predict from the pre-write config, then apply writes
  task automatic cyc(input string tag, input bit iv, input logic [FID_W-1:0] fid,
                     input logic [W-1:0] a, input logic [W-1:0] b,
                     input bit fwe, input logic [FID_W-1:0] fnew,
                     input bit lwe, input int lsel, input logic [15:0] lbits);
    logic ev, ef;
    logic [W-1:0] ed;
    iss_vld = iv; iss_fid = fid; iss_a = a; iss_b = b;
    cfg_fid_we = fwe; cfg_fid = fnew;
    cfg_lut_we = lwe; cfg_lut_sel = SEL_W'(lsel); cfg_lut_bits = lbits;
    ev = 1'b0; ef = 1'b0; ed = '0;
    if (iv) begin
      if (m_ok && fid == m_fid) begin ev = 1'b1; ed = model_fn(a, b); end
      else ef = 1'b1;
    end
    if (fwe) begin m_ok = 1'b1; m_fid = fnew; end
    if (lwe) m_tbl[lsel] = lbits;
    @(posedge clk); #1;
    check(tag, ev, ef, ed);
  endtask

  task automatic load_all(input logic [15:0] bits);
    for (int s = 0; s < W; s++) cyc("R7", 0, '0, '0, '0, 0, '0, 1, s, bits);
  endtask

  task automatic issue(input string tag, input logic [FID_W-1:0] fid,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    cyc(tag, 1, fid, a, b, 0, '0, 0, 0, '0);
  endtask

  initial begin
    #(4*100000);
    bad++; total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < W; s++) m_tbl[s] = '0;
    repeat (3) @(posedge clk);
    #1; check("R1", 1'b0, 1'b0, '0);
    rst = 1'b0;
    cyc("R1", 0, '0, '0, '0, 0, '0, 0, 0, '0);
    // R2: issue with nothing loaded
    issue("R2", 11'h005, 32'hFFFF_0000, 32'h1234_5678);
    issue("R2", 11'h000, 32'h0, 32'h0);
    // R3: XOR on every slice (table 0x6666), ID 0x123
    load_all(16'h6666);
    cyc("R7", 0, '0, '0, '0, 1, 11'h123, 0, 0, '0);
    issue("R3", 11'h123, 32'hDEAD_BEEF, 32'h1234_5678);
    issue("R7", 11'h123, 32'h0F0F_0F0F, 32'hFFFF_FFFF);
    issue("R3", 11'h123, 32'hAAAA_5555, 32'hAAAA_5555);
    // R4 / R9: mismatching IDs
    issue("R4", 11'h122, 32'h1, 32'h2);
    cyc("R7", 0, '0, 32'h1, 32'h2, 0, '0, 0, 0, '0);
    issue("R9", 11'h523, 32'h1, 32'h2);
    issue("R4", 11'h7FF, 32'h3, 32'h4);
    // R5: table address order and zero below bit 0
    load_all(16'hF0F0);  // A[i-1]
    issue("R5", 11'h123, 32'h8000_0001, 32'h0);
    load_all(16'hFF00);  // B[i-1]
    issue("R5", 11'h123, 32'hFFFF_FFFF, 32'hC000_0003);
    load_all(16'hAAAA);  // A[i]
    issue("R5", 11'h123, 32'h1357_9BDF, 32'hFFFF_FFFF);
    load_all(16'hCCCC);  // B[i]
    issue("R5", 11'h123, 32'hFFFF_FFFF, 32'h2468_ACE0);
    load_all(16'h0000);
    cyc("R5", 0, '0, '0, '0, 0, '0, 1, 0, 16'hFFFF);
    issue("R5", 11'h123, 32'h0, 32'h0);
    // R6: same-cycle ID write is not seen by that issue
    load_all(16'hAAAA);
    cyc("R6", 1, 11'h123, 32'hFFFF_FFFF, 32'h0, 1, 11'h0AB, 0, 0, '0);
    issue("R6", 11'h123, 32'hFFFF_FFFF, 32'h0);
    issue("R6", 11'h0AB, 32'hFFFF_FFFF, 32'h0);
    // R6: same-cycle table write is not seen by that issue
    cyc("R6", 1, 11'h0AB, 32'hFFFF_FFFF, 32'h0, 0, '0, 1, 3, 16'h0000);
    issue("R6", 11'h0AB, 32'hFFFF_FFFF, 32'h0);
    // R7: idle cycles stay quiet
    repeat (3) cyc("R7", 0, 11'h0AB, 32'hFFFF_FFFF, 32'h1, 0, '0, 0, 0, '0);
    // R1: reset clears loaded state
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", 1'b0, 1'b0, '0);
    rst = 1'b0; m_ok = 1'b0; m_fid = '0;
    issue("R1", 11'h000, 32'h1, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule